// File: doc/BRIEF.md
# Master Clock Frequency Window Monitor

This block checks the rate of a fast audio master clock against a steady system clock. It runs windows of a fixed number of system-clock cycles back to back, with no gap between them. In each window it counts the rising edges of the master clock. At the end of every window it stores that count in a register that software can read.

Each stored count is compared with a programmable lower and upper limit. When the count falls outside those limits, a sticky error bit sets. The bit stays set until software pulses a clear. The master clock is counted in its own domain. The running count crosses into the system domain as a Gray code through a two-flop synchronizer. The system side computes each window's count as the difference between successive snapshots.

Top module: `mclk_range_mon`

## Requirements
- R1: While reset is asserted and right after it, `mclk_count` is 0 and `range_err` is 0.
- R2: `mclk_count` equals the number of master-clock rising edges in the last WIN-cycle system window, within ±1 edge for sampling uncertainty.
- R3: A window count above 2^CW−1 is reported as 2^CW−1 and does not wrap.
- R4: A count below `lim_lo` sets `range_err` at that window's end.
- R5: A count above `lim_hi` sets `range_err` at that window's end.
- R6: A count with `lim_lo` ≤ count ≤ `lim_hi` (both limits inclusive) does not set `range_err`.
- R7: `range_err` stays set until `err_clr` is high at a rising system-clock edge. With no violation in that edge, the edge clears it.
- R8: If `err_clr` is high at the same edge that ends a violating window, `range_err` stays 1.
- R9: The first window after reset is partial, so it is never checked against the limits.
- R10: `mclk_count` and a rising `range_err` change only at window ends. Window ends fall at system-clock edges WIN, 2·WIN, … after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Stable reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mclk | input | 1 | Master clock being measured |
| lim_lo | input | CW | Lowest acceptable count (inclusive) |
| lim_hi | input | CW | Highest acceptable count (inclusive) |
| err_clr | input | 1 | Clears the sticky error flag |
| mclk_count | output | CW | Edge count of the last complete window |
| range_err | output | 1 | Sticky out-of-range flag |

## Verification
The bench builds the block with WIN=32 and CW=6, which caps the count at 63. A master clock with a 2 ns period gives 80 edges per window and so exercises saturation, while 10 ns and 20 ns periods give 16 and 8 edges. The bench counts system edges from reset release. This lets it place a clear exactly on a window-end edge or well away from one. The checks cover the clear-versus-violation priority and the count staying unchanged inside a window.

// File: rtl/mclk_range_mon.sv
module mclk_range_mon #(
  parameter int WIN = 32,
  parameter int CW  = 10
) (
  input  logic          sys_clk,
  input  logic          rst_n,
  input  logic          mclk,
  input  logic [CW-1:0] lim_lo,
  input  logic [CW-1:0] lim_hi,
  input  logic          err_clr,
  output logic [CW-1:0] mclk_count,
  output logic          range_err
);
  localparam int GW = CW + 2;
  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [GW-1:0] SAT = {2'b00, {CW{1'b1}}};

  // master-clock domain: binary counter with registered Gray copy
  logic [GW-1:0] mbin, mgray, mnext;
  assign mnext = mbin + 1'b1;

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) begin
      mbin  <= '0;
      mgray <= '0;
    end else begin
      mbin  <= mnext;
      mgray <= mnext ^ (mnext >> 1);
    end

  // system domain
  logic [GW-1:0] s1, s2, sbin, prev, delta;
  logic [WW-1:0] wcnt;
  logic          win_end, primed, viol;
  logic [CW-1:0] cnt_n;

  always_comb
    for (int i = 0; i < GW; i++) sbin[i] = ^(s2 >> i);

  assign win_end = (wcnt == WW'(WIN - 1));
  assign delta   = sbin - prev;
  assign cnt_n   = (delta > SAT) ? SAT[CW-1:0] : delta[CW-1:0];
  assign viol    = (cnt_n < lim_lo) || (cnt_n > lim_hi);

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      s1         <= '0;
      s2         <= '0;
      wcnt       <= '0;
      prev       <= '0;
      primed     <= 1'b0;
      mclk_count <= '0;
      range_err  <= 1'b0;
    end else begin
      s1        <= mgray;
      s2        <= s1;
      wcnt      <= win_end ? '0 : wcnt + 1'b1;
      primed    <= primed | win_end;
      range_err <= (win_end && primed && viol) || (range_err && !err_clr);
      if (win_end) begin
        prev       <= sbin;
        mclk_count <= cnt_n;
      end
    end
endmodule

// File: rtl/mclk_range_mon_chk.sv
module mclk_range_mon_chk #(
  parameter int WIN = 32,
  parameter int CW  = 10
) (
  input logic          sys_clk,
  input logic          rst_n,
  input logic [CW-1:0] lim_lo,
  input logic [CW-1:0] lim_hi,
  input logic          err_clr,
  input logic [CW-1:0] mclk_count,
  input logic          range_err
);
  localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
  logic [WW-1:0] ck;
  logic [1:0]    wins;
  logic          edge_now;
  assign edge_now = (ck == WW'(WIN - 1));

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      ck   <= '0;
      wins <= '0;
    end else begin
      ck <= edge_now ? '0 : ck + 1'b1;
      if (edge_now && wins != 2'd2) wins <= wins + 1'b1;
    end

  // R10
  count_at_boundary_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !$stable(mclk_count) |-> $past(ck) == WW'(WIN - 1));

  // R10
  err_rise_boundary_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(range_err) |-> $past(ck) == WW'(WIN - 1));

  // R7
  err_sticky_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (range_err && !err_clr) |=> range_err);

  // R4
  low_viol_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    ($past(ck) == WW'(WIN - 1) && $past(wins) != 2'd0 && mclk_count < $past(lim_lo)) |-> range_err);

  // R5
  high_viol_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    ($past(ck) == WW'(WIN - 1) && $past(wins) != 2'd0 && mclk_count > $past(lim_hi)) |-> range_err);

  // R9
  first_window_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    ($past(ck) == WW'(WIN - 1) && $past(wins) == 2'd0) |-> !range_err);
endmodule

bind mclk_range_mon mclk_range_mon_chk #(.WIN(WIN), .CW(CW)) u_chk (
  .sys_clk(sys_clk), .rst_n(rst_n), .lim_lo(lim_lo), .lim_hi(lim_hi),
  .err_clr(err_clr), .mclk_count(mclk_count), .range_err(range_err));

// File: tb/sim_mclk_range_mon.sv
`timescale 1ns/1ps
module sim_mclk_range_mon;
  localparam int WIN = 32;
  localparam int CW  = 6;

  logic sys_clk = 0, mclk = 0, rst_n = 0, err_clr = 0;
  logic [CW-1:0] lim_lo = 0, lim_hi = 0, mclk_count;
  logic range_err;
  real mhalf = 5.0;
  int total = 0, bad = 0, cyc = 0;

  mclk_range_mon #(.WIN(WIN), .CW(CW)) u0 (
    .sys_clk(sys_clk), .rst_n(rst_n), .mclk(mclk), .lim_lo(lim_lo),
    .lim_hi(lim_hi), .err_clr(err_clr), .mclk_count(mclk_count), .range_err(range_err));

  always #2.5 sys_clk = ~sys_clk;
  always begin #(mhalf); mclk = ~mclk; end
  always @(posedge sys_clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(string req, int act, int lo, int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic to_off(int o);
    do @(negedge sys_clk); while (cyc % WIN != o);
  endtask

  task automatic windows(int n);
    repeat (n * WIN) @(negedge sys_clk);
  endtask

  task automatic t_reset_first;
    lim_lo = 50; lim_hi = 60; mhalf = 5.0;
    rst_n = 0; repeat (5) @(negedge sys_clk);
    chk("R1 count", mclk_count, 0, 0);
    chk("R1 err", range_err, 0, 0);
    rst_n = 1;
    @(negedge sys_clk);
    chk("R1 err after release", range_err, 0, 0);
    to_off(1);
    chk("R9 first window unchecked", range_err, 0, 0);
    to_off(1);
    chk("R4 second window low", range_err, 1, 1);
  endtask

  task automatic t_counts;
    lim_lo = 0; lim_hi = 63;
    to_off(5); err_clr = 1; @(negedge sys_clk); err_clr = 0;
    chk("R7 clear", range_err, 0, 0);
    windows(3); to_off(3);
    chk("R2 10ns period", mclk_count, 15, 17);
    mhalf = 10.0; windows(3); to_off(3);
    chk("R2 20ns period", mclk_count, 7, 9);
    mhalf = 2.0; windows(3); to_off(3);
    chk("R2 4ns period", mclk_count, 39, 41);
    mhalf = 1.0; windows(3); to_off(3);
    chk("R3 saturation", mclk_count, 63, 63);
    mhalf = 5.0; windows(3);
  endtask

  task automatic t_stable;
    int v;
    to_off(1); v = mclk_count;
    for (int k = 0; k < WIN - 2; k++) begin
      @(negedge sys_clk);
      chk("R10 stable in window", mclk_count, v, v);
    end
  endtask

  task automatic t_bounds;
    lim_lo = 15; lim_hi = 17; windows(4);
    chk("R6 inside bounds", range_err, 0, 0);
    lim_lo = 20; windows(2); to_off(2);
    chk("R4 below min", range_err, 1, 1);
    lim_lo = 0; lim_hi = 63; windows(3);
    chk("R7 sticky", range_err, 1, 1);
    to_off(12); err_clr = 1; @(negedge sys_clk); err_clr = 0;
    chk("R7 cleared", range_err, 0, 0);
    lim_hi = 10; windows(2); to_off(2);
    chk("R5 above max", range_err, 1, 1);
  endtask

  task automatic t_collide;
    to_off(WIN - 1); err_clr = 1; @(negedge sys_clk); err_clr = 0;
    chk("R8 clear at violating window end", range_err, 1, 1);
    to_off(10); err_clr = 1; @(negedge sys_clk); err_clr = 0;
    chk("R7 clear mid window", range_err, 0, 0);
    to_off(WIN - 2);
    chk("R10 no rise mid window", range_err, 0, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_first; t_counts; t_stable; t_bounds; t_collide;
      end
      begin
        repeat (100000) @(posedge sys_clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule